// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block watches a bank of interrupt lines, numbered 0 to NLVL-1, and decides which request the processor should take next. A lower number is more urgent. A request line is latched as pending when it rises. The controller offers the most urgent eligible request together with its handler vector address and the return address the processor must push.

When the processor takes the request, the controller pushes the level and the processor's current privilege mode onto a small in-service stack. While a level is on top of that stack, only strictly lower-numbered (more urgent) requests may pre-empt it. When the handler finishes, software pulses end-of-interrupt. The controller then pops the top entry and shows the mode to restore. An end-of-interrupt with nothing in service is refused and flagged.

The privilege mode is a 2-bit code: 0 is kernel and 3 is user. The controller only stores and returns it. Vector addresses and the return address are purely combinational from the current inputs and state. Pending and stack state change on the clock edge.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A 0-to-1 transition on `irq_i[k]` marks level k pending at the next clock edge. A line held high does not mark the level pending again after it has been taken. After reset, every line counts as previously low.
- R2: With the stack empty, `req_o` is high whenever any level is pending, and `lvl_o` is the lowest-numbered pending level.
- R3: While `req_o` is high, `vec_o` equals `vbase_i + 4 * lvl_o`, modulo 2^AW.
- R4: `ret_pc_o` always equals `pc_i + 4`, modulo 2^AW.
- R5: A take is accepted when `take_i` and `req_o` are high and `eoi_i` is low. At the next edge, `depth_o` rises by one, `isr_lvl_o` shows the taken level, and that level is no longer pending.
- R6: While the stack is non-empty with top level t, only pending levels strictly below t are offered, the lowest first.
- R7: With `depth_o` equal to DEPTH (default 4), `req_o` stays low and `take_i` has no effect.
- R8: While `depth_o` is non-zero, `restore_mode_o` shows the `mode_i` value captured when the top entry was taken. An end-of-interrupt pops that entry at the next edge, which exposes the entry below it.
- R9: An end-of-interrupt with an empty stack changes no state except `eoi_err_o`, which goes high at the next edge and stays high until reset.
- R10: If `take_i` and `eoi_i` are both high in one cycle, only the end-of-interrupt acts. The offered level stays pending.
- R11: During and right after reset, `depth_o` is 0, nothing is pending, `req_o` is low and `eoi_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NLVL | Interrupt request lines, one per level |
| vbase_i | input | AW | Base address of the handler vector table |
| pc_i | input | AW | Address of the instruction being executed |
| mode_i | input | 2 | Current privilege mode, captured on take |
| take_i | input | 1 | Processor accepts the offered request |
| eoi_i | input | 1 | End-of-interrupt for the level on top of the stack |
| req_o | output | 1 | An eligible request is offered |
| lvl_o | output | LW | Offered level |
| vec_o | output | AW | Handler vector address for the offered level |
| ret_pc_o | output | AW | Return address to push on take |
| depth_o | output | DW | Number of levels in service |
| isr_lvl_o | output | LW | Level on top of the in-service stack |
| restore_mode_o | output | 2 | Mode saved with the top stack entry |
| eoi_err_o | output | 1 | Sticky flag for end-of-interrupt on an empty stack |

## Verification
`vec_o`, `ret_pc_o`, `req_o` and `lvl_o` respond in the same cycle to `vbase_i`, `pc_i` and the current state. A rising request line affects them one edge later. A take or an end-of-interrupt changes `depth_o`, `isr_lvl_o`, `restore_mode_o` and `eoi_err_o` one edge later. The bench drives inputs 1 ns after a rising edge and compares every output 1 ns later, against a model it updates once per edge. Each result is therefore checked in exactly the cycle in which it is due.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef logic [1:0] priv_t;
  localparam priv_t PRIV_KERNEL = 2'd0;
  localparam priv_t PRIV_USER   = 2'd3;
  // bytes per vector slot and per instruction
  localparam int unsigned SLOT_BYTES = 4;
endpackage

// File: rtl/nic_pending.sv
module nic_pending #(
  parameter int unsigned NLVL = 32,
  parameter int unsigned LW   = $clog2(NLVL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NLVL-1:0] irq_i,
  input  logic            clr_vld_i,
  input  logic [LW-1:0]   clr_idx_i,
  output logic [NLVL-1:0] pend_o
);
  logic [NLVL-1:0] irq_q;
  logic [NLVL-1:0] pend_q;
  logic [NLVL-1:0] rise_w;
  logic [NLVL-1:0] clr_w;

  assign rise_w = irq_i & ~irq_q;

  for (genvar g = 0; g < NLVL; g++) begin : g_clr
    assign clr_w[g] = clr_vld_i && (clr_idx_i == LW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= (pend_q & ~clr_w) | rise_w;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/nic_select.sv
module nic_select #(
  parameter int unsigned NLVL = 32,
  parameter int unsigned LW   = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] pend_i,
  input  logic            top_vld_i,
  input  logic [LW-1:0]   top_lvl_i,
  output logic            hit_o,
  output logic [LW-1:0]   lvl_o
);
  logic [NLVL-1:0] allow_w;
  logic [NLVL-1:0] elig_w;

  function automatic logic [LW-1:0] first_set(input logic [NLVL-1:0] v);
    logic [LW-1:0] idx;
    idx = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (v[i]) idx = LW'(i);
    end
    return idx;
  endfunction

  for (genvar g = 0; g < NLVL; g++) begin : g_mask
    assign allow_w[g] = !top_vld_i || (LW'(g) < top_lvl_i);
  end

  assign elig_w = pend_i & allow_w;
  assign hit_o  = |elig_w;
  assign lvl_o  = first_set(elig_w);
endmodule

// File: rtl/nic_stack.sv
module nic_stack
  import nic_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LW    = 5,
  parameter int unsigned DW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [LW-1:0] push_lvl_i,
  input  priv_t         push_mode_i,
  input  logic          pop_i,
  output logic [DW-1:0] depth_o,
  output logic [LW-1:0] top_lvl_o,
  output priv_t         top_mode_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [LW-1:0] lvl_q  [DEPTH];
  priv_t         mode_q [DEPTH];
  logic [DW-1:0] depth_q;
  logic [IW-1:0] top_idx_w;

  assign empty_o   = (depth_q == '0);
  assign full_o    = (depth_q == DW'(DEPTH));
  assign top_idx_w = IW'(depth_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int s = 0; s < DEPTH; s++) begin
        lvl_q[s]  <= '0;
        mode_q[s] <= PRIV_KERNEL;
      end
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (push_i && depth_q == DW'(s)) begin
          lvl_q[s]  <= push_lvl_i;
          mode_q[s] <= push_mode_i;
        end
      end
      if (push_i)     depth_q <= depth_q + 1'b1;
      else if (pop_i) depth_q <= depth_q - 1'b1;
    end
  end

  assign depth_o    = depth_q;
  assign top_lvl_o  = empty_o ? '0 : lvl_q[top_idx_w];
  assign top_mode_o = empty_o ? PRIV_KERNEL : mode_q[top_idx_w];
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned NLVL  = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LW    = $clog2(NLVL),
  parameter int unsigned DW    = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NLVL-1:0] irq_i,
  input  logic [AW-1:0]   vbase_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [1:0]      mode_i,
  input  logic            take_i,
  input  logic            eoi_i,
  output logic            req_o,
  output logic [LW-1:0]   lvl_o,
  output logic [AW-1:0]   vec_o,
  output logic [AW-1:0]   ret_pc_o,
  output logic [DW-1:0]   depth_o,
  output logic [LW-1:0]   isr_lvl_o,
  output logic [1:0]      restore_mode_o,
  output logic            eoi_err_o
);
  function automatic logic [AW-1:0] vec_addr(input logic [AW-1:0] base,
                                             input logic [LW-1:0] lvl);
    return base + AW'(lvl) * AW'(SLOT_BYTES);
  endfunction

  function automatic logic [AW-1:0] next_pc(input logic [AW-1:0] pc);
    return pc + AW'(SLOT_BYTES);
  endfunction

  logic [NLVL-1:0] pend_w;
  logic            hit_w;
  logic [LW-1:0]   sel_lvl_w;
  logic            stk_empty_w;
  logic            stk_full_w;
  logic [LW-1:0]   top_lvl_w;
  priv_t           top_mode_w;
  logic            push_w;
  logic            pop_w;
  logic            eoi_bad_w;
  logic            err_q;

  nic_pending #(.NLVL(NLVL), .LW(LW)) pend_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .clr_vld_i (push_w),
    .clr_idx_i (sel_lvl_w),
    .pend_o    (pend_w)
  );

  nic_select #(.NLVL(NLVL), .LW(LW)) sel_i (
    .pend_i    (pend_w),
    .top_vld_i (!stk_empty_w),
    .top_lvl_i (top_lvl_w),
    .hit_o     (hit_w),
    .lvl_o     (sel_lvl_w)
  );

  nic_stack #(.DEPTH(DEPTH), .LW(LW), .DW(DW)) stk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_w),
    .push_lvl_i  (sel_lvl_w),
    .push_mode_i (mode_i),
    .pop_i       (pop_w),
    .depth_o     (depth_o),
    .top_lvl_o   (top_lvl_w),
    .top_mode_o  (top_mode_w),
    .empty_o     (stk_empty_w),
    .full_o      (stk_full_w)
  );

  assign req_o     = hit_w && !stk_full_w;
  assign push_w    = take_i && req_o && !eoi_i;
  assign pop_w     = eoi_i && !stk_empty_w;
  assign eoi_bad_w = eoi_i && stk_empty_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | eoi_bad_w;
  end

  assign lvl_o          = sel_lvl_w;
  assign vec_o          = vec_addr(vbase_i, sel_lvl_w);
  assign ret_pc_o       = next_pc(pc_i);
  assign isr_lvl_o      = top_lvl_w;
  assign restore_mode_o = top_mode_w;
  assign eoi_err_o      = err_q;
endmodule

// File: rtl/nic_ctrl_chk.sv
module nic_ctrl_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LW    = 5,
  parameter int unsigned DW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_o,
  input logic [LW-1:0] lvl_o,
  input logic [DW-1:0] depth_o,
  input logic [LW-1:0] isr_lvl_o,
  input logic          take_i,
  input logic          eoi_i,
  input logic          push_w,
  input logic          pop_w,
  input logic          eoi_err_o
);
  p_push_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_w |=> (depth_o == DW'($past(depth_o) + 1'b1)) && (isr_lvl_o == $past(lvl_o)));

  p_nest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && depth_o != '0) |-> (lvl_o < isr_lvl_o));

  p_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DW'(DEPTH));

  p_full_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == DW'(DEPTH)) |-> !req_o);

  p_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_w |=> (depth_o == DW'($past(depth_o) - 1'b1)));

  p_empty_eoi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && depth_o == '0) |=> (eoi_err_o && depth_o == '0));

  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_err_o |=> eoi_err_o);

  p_tie_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && eoi_i && depth_o != '0) |=> (depth_o == DW'($past(depth_o) - 1'b1)));
endmodule

bind nest_irq_ctrl nic_ctrl_chk #(.DEPTH(DEPTH), .LW(LW), .DW(DW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_o     (req_o),
  .lvl_o     (lvl_o),
  .depth_o   (depth_o),
  .isr_lvl_o (isr_lvl_o),
  .take_i    (take_i),
  .eoi_i     (eoi_i),
  .push_w    (push_w),
  .pop_w     (pop_w),
  .eoi_err_o (eoi_err_o)
);

// File: tb/nest_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb_top;
  localparam int NLVL  = 32;
  localparam int AW    = 32;
  localparam int DEPTH = 4;
  localparam int LW    = 5;
  localparam int DW    = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NLVL-1:0] irq = '0;
  logic [AW-1:0]   base = '0;
  logic [AW-1:0]   pc = '0;
  logic [1:0]      mode = '0;
  logic            take = 1'b0;
  logic            eoi = 1'b0;
  logic            req_o;
  logic [LW-1:0]   lvl_o;
  logic [AW-1:0]   vec_o;
  logic [AW-1:0]   ret_pc_o;
  logic [DW-1:0]   depth_o;
  logic [LW-1:0]   isr_lvl_o;
  logic [1:0]      restore_mode_o;
  logic            eoi_err_o;

  always #2 clk = ~clk;

  nest_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .vbase_i(base), .pc_i(pc),
    .mode_i(mode), .take_i(take), .eoi_i(eoi), .req_o(req_o), .lvl_o(lvl_o),
    .vec_o(vec_o), .ret_pc_o(ret_pc_o), .depth_o(depth_o), .isr_lvl_o(isr_lvl_o),
    .restore_mode_o(restore_mode_o), .eoi_err_o(eoi_err_o)
  );

  int nvec = 0;
  int nfail = 0;

  // reference model state
  logic [NLVL-1:0] m_pend = '0;
  logic [NLVL-1:0] m_irq_q = '0;
  int              m_depth = 0;
  int              m_lvl [DEPTH];
  logic [1:0]      m_mode [DEPTH];
  bit              m_err = 0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pick(output bit found, output int idx);
    found = 0;
    idx = 0;
    for (int j = 0; j < NLVL; j++) begin
      if (m_pend[j] && (m_depth == 0 || j < m_lvl[m_depth-1])) begin
        found = 1;
        idx = j;
        break;
      end
    end
  endtask

  // inputs already set 1 ns after an edge; compare, advance model, pass edge
  task automatic cyc();
    bit found;
    int idx;
    bit req_e;
    bit take_ok;
    logic [AW-1:0] exp_vec;
    logic [AW-1:0] exp_pc;
    #1;
    pick(found, idx);
    req_e = found && (m_depth < DEPTH);
    chk(m_depth == DEPTH ? "R7" : "R2", "req_o", 64'(req_o), 64'(req_e));
    if (req_e) begin
      chk(m_depth == 0 ? "R2" : "R6", "lvl_o", 64'(lvl_o), 64'(idx));
      exp_vec = base + AW'(idx * 4);
      chk("R3", "vec_o", 64'(vec_o), 64'(exp_vec));
    end
    exp_pc = pc + 32'd4;
    chk("R4", "ret_pc_o", 64'(ret_pc_o), 64'(exp_pc));
    chk("R5", "depth_o", 64'(depth_o), 64'(m_depth));
    if (m_depth > 0) begin
      chk("R5", "isr_lvl_o", 64'(isr_lvl_o), 64'(m_lvl[m_depth-1]));
      chk("R8", "restore_mode_o", 64'(restore_mode_o), 64'(m_mode[m_depth-1]));
    end
    chk("R9", "eoi_err_o", 64'(eoi_err_o), 64'(m_err));
    take_ok = take && req_e && !eoi;
    if (take_ok) m_pend[idx] = 1'b0;
    m_pend = m_pend | (irq & ~m_irq_q);
    m_irq_q = irq;
    if (eoi) begin
      if (m_depth > 0) m_depth--;
      else m_err = 1;
    end else if (take_ok) begin
      m_lvl[m_depth] = idx;
      m_mode[m_depth] = mode;
      m_depth++;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic take_one(input logic [1:0] md);
    mode = md; take = 1'b1; cyc(); take = 1'b0;
  endtask

  task automatic eoi_one();
    eoi = 1'b1; cyc(); eoi = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int s = 0; s < DEPTH; s++) begin m_lvl[s] = 0; m_mode[s] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R11: state held in reset
    chk("R11", "req_o in reset", 64'(req_o), 64'd0);
    chk("R11", "depth_o in reset", 64'(depth_o), 64'd0);
    chk("R11", "eoi_err_o in reset", 64'(eoi_err_o), 64'd0);
    rst_n = 1'b1;
    cyc();

    // single level sweep: R1 R2 R3 R4 R5 R8
    for (int k = 0; k < NLVL; k++) begin
      base = 32'h4000_0000 + 32'(k) * 32'h0000_0130;
      pc = (k == NLVL - 1) ? 32'hFFFF_FFFC : 32'h0000_8000 + 32'(k) * 32'h0000_0104;
      irq = NLVL'(1) << k;
      cyc();
      chk("R1", "req_o after rise", 64'(req_o), 64'd1);
      cyc();
      take_one(2'(k % 4));
      cyc();
      eoi_one();
      cyc();
      chk("R1", "held line not pending again", 64'(req_o), 64'd0);
      irq = '0;
      cyc();
    end

    // mask sweep over every in-service level: R6 R2
    for (int t = 0; t < NLVL; t++) begin
      base = 32'h0001_0000 + 32'(t);
      irq = NLVL'(1) << t;
      cyc();
      take_one(2'd3);
      irq = ~(NLVL'(1) << t);
      cyc();
      cyc();
      chk("R6", "req_o under mask", 64'(req_o), 64'(t > 0));
      eoi_one();
      for (int d = 0; d < NLVL - 1; d++) begin
        take_one(2'(d % 4));
        eoi_one();
      end
      irq = '0;
      cyc();
    end

    // nesting to full depth: R7 R8 R9
    irq = NLVL'(1) << 31; cyc(); take_one(2'd3);
    irq = irq | (NLVL'(1) << 20); cyc(); take_one(2'd1);
    irq = irq | (NLVL'(1) << 10); cyc(); take_one(2'd2);
    irq = irq | (NLVL'(1) << 5);  cyc(); take_one(2'd0);
    irq = irq | NLVL'(1);
    cyc();
    cyc();
    chk("R7", "req_o when full", 64'(req_o), 64'd0);
    take_one(2'd3);
    cyc();
    chk("R7", "depth_o after refused take", 64'(depth_o), 64'(DEPTH));
    chk("R8", "restore_mode_o top", 64'(restore_mode_o), 64'd0);
    eoi_one(); cyc();
    eoi_one(); cyc();
    eoi_one(); cyc();
    chk("R8", "restore_mode_o bottom", 64'(restore_mode_o), 64'd3);
    eoi_one(); cyc();
    chk("R9", "eoi_err_o before empty eoi", 64'(eoi_err_o), 64'd0);
    eoi_one(); cyc();
    chk("R9", "eoi_err_o after empty eoi", 64'(eoi_err_o), 64'd1);
    chk("R9", "depth_o after empty eoi", 64'(depth_o), 64'd0);
    take_one(2'd1); eoi_one();
    irq = '0; cyc();

    // take and end-of-interrupt together: R10
    irq = NLVL'(1) << 12; cyc(); take_one(2'd3);
    irq = irq | (NLVL'(1) << 3); cyc();
    take = 1'b1; eoi = 1'b1; cyc(); take = 1'b0; eoi = 1'b0;
    chk("R10", "depth_o after tie", 64'(depth_o), 64'd0);
    chk("R10", "level still offered", 64'(req_o), 64'd1);
    chk("R10", "offered level", 64'(lvl_o), 64'd3);
    take_one(2'd0); eoi_one();
    irq = '0; cyc(); cyc();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule